// File: doc/BRIEF.md
# Oscillator Start-Up Delay Supervisor

This block stands between two free-running oscillator sources and the logic they feed. One source is a fast main oscillator, the other a slow low-speed oscillator. After power-on, or after a source has been stopped and started again, an oscillator needs time to settle. Each source therefore has its own down-counter, clocked by that source. The counter is loaded with all ones, and a "clock good" flag is raised only when it reaches zero. Until then the gated clock handed to the rest of the chip is held low.

The block also builds the chip's system reset. Power-on reset and an external reset pin are combined, synchronised into the fast domain, and then held off until the main clock is good. Each good flag is also carried into the other clock domain through a two-flop synchroniser, so that logic running on either clock can watch both sources.

Stop requests are level inputs, one for each source, and each is sampled by its own clock. A stop clears the matching good flag at once and reloads the counter. Power-on reset (active low) clears all state asynchronously. The external reset only affects the system reset and never restarts a counter.

Top module: `osc_startup_sup`

## Requirements
- R1: While por_n_i is low, fast_good_o, slow_good_o, both cross-domain good flags, sys_rst_n_o and both gated clock outputs are all low. Power-on reset clears them asynchronously, without waiting for a clock edge.
- R2: With fast_stop_i low, fast_good_o first goes high on the 16385th rising edge of fast_osc_i after por_n_i rises. This is two edges of reset synchronisation followed by a count of 16383 from the all-ones preset down to zero.
- R3: With slow_stop_i low, slow_good_o first goes high on the 65th rising edge of slow_osc_i after por_n_i rises, which is two synchronising edges followed by 63 counts.
- R4: While a stop input is high, the matching good output is low at once, without waiting for an edge. Every edge that samples the stop high reloads the counter with all ones. Once the stop is low again, the good output rises on the 16383rd (fast) or 63rd (slow) rising edge that samples it low.
- R5: If a stop input is sampled high on the very edge at which the counter would reach zero, the stop wins. The good flag stays low and the full delay starts over.
- R6: Each gated clock output equals its source clock while an enable register is high, and is low otherwise. The enable register loads the good output on the falling edge of its source, so no clock pulse is ever cut short.
- R7: sys_rst_n_o goes low at once, without waiting for a clock edge, whenever por_n_i or ext_rst_n_i is low.
- R8: sys_rst_n_o is a fast-domain register. It loads (two-flop synchronised reset release AND fast_good_o) on each rising fast edge. So it rises one edge after fast_good_o rises, or on the third edge after the external reset is released, whichever comes later. It falls on the first edge that samples fast_good_o low.
- R9: slow_good_fast_o is slow_good_o passed through two fast_osc_i flops. fast_good_slow_o is fast_good_o passed through two slow_osc_i flops.
- R10: Pulling ext_rst_n_i low has no effect on either counter or good flag: both good flags stay high throughout an external reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_osc_i | input | 1 | Raw main oscillator clock |
| slow_osc_i | input | 1 | Raw low-speed oscillator clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| fast_stop_i | input | 1 | Stop request for the main oscillator, sampled by fast_osc_i |
| slow_stop_i | input | 1 | Stop request for the low-speed oscillator, sampled by slow_osc_i |
| fast_clk_o | output | 1 | Gated main clock to the system |
| slow_clk_o | output | 1 | Gated low-speed clock to the system |
| fast_good_o | output | 1 | Main clock settled (fast domain) |
| slow_good_o | output | 1 | Low-speed clock settled (slow domain) |
| slow_good_fast_o | output | 1 | slow_good_o synchronised into the fast domain |
| fast_good_slow_o | output | 1 | fast_good_o synchronised into the slow domain |
| sys_rst_n_o | output | 1 | System reset, active low, fast domain |

## Verification
Two pairs of events can land on the same edge. In the slow domain, a stop request can arrive on the very edge at which the counter would reach zero; the bench counts 62 edges after a stop release, raises the stop again before the 63rd, then drops it and expects the good flag to be still low and a fresh 63-edge delay to follow. In the fast domain, the synchronised external-reset release can complete on the edge where the main good flag rises; the bench releases the pin after exactly 16383 edges so both paths are satisfied together. It then expects sys_rst_n_o high on the next edge, judged against a behavioural model that follows every edge of both clocks.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;

  // Counter widths: the settle delay is (2**W - 1) source cycles.
  localparam int unsigned DEF_FAST_W = 14;
  localparam int unsigned DEF_SLOW_W = 6;

  // Flops in every synchroniser chain.
  localparam int unsigned DEF_SYNC_N = 2;

  // Status handed from a settle timer to the top level.
  typedef struct packed {
    logic good;
    logic gate;
  } tmr_stat_t;

endpackage

// File: rtl/sup_sync.sv
// Multi-flop synchroniser with asynchronous active-low clear.
module sup_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_d = d_i;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/sup_settle_timer.sv
// Per-source settle counter, good flag and glitch-free clock gate.
module sup_settle_timer
  import osc_sup_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] cnt_o,
  output tmr_stat_t        stat_o,
  output logic             good_o,
  output logic             clk_o
);

  localparam logic [CNT_W-1:0] PRESET = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE    = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO   = {CNT_W{1'b0}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             good_q;
  logic             good_d;
  logic             cnt_en;
  logic             gate_q;
  logic             gate_d;

  // Next-state: stop reloads and clears; otherwise count toward zero.
  always_comb begin
    cnt_d  = cnt_q;
    good_d = good_q;
    cnt_en = stop_i | (cnt_q != ZERO);
    if (stop_i) begin
      cnt_d  = PRESET;
      good_d = 1'b0;
    end else if (cnt_q != ZERO) begin
      cnt_d  = cnt_q - ONE;
      good_d = (cnt_q == ONE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q  <= PRESET;
      good_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
    end
  end

  // Stop drops the flag without waiting for an edge.
  assign good_o = good_q & ~stop_i;

  // Gate enable moves only while the source is low.
  always_comb gate_d = good_o;

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
    end
  end

  assign clk_o       = clk_i & gate_q;
  assign cnt_o       = cnt_q;
  assign stat_o.good = good_o;
  assign stat_o.gate = gate_q;

endmodule

// File: rtl/osc_startup_sup.sv
// Oscillator start-up supervisor: two settle timers and system reset.
module osc_startup_sup
  import osc_sup_pkg::*;
#(
  parameter int unsigned FAST_CNT_W = DEF_FAST_W,
  parameter int unsigned SLOW_CNT_W = DEF_SLOW_W,
  parameter int unsigned SYNC_N     = DEF_SYNC_N
) (
  input  logic fast_osc_i,
  input  logic slow_osc_i,
  input  logic por_n_i,
  input  logic ext_rst_n_i,
  input  logic fast_stop_i,
  input  logic slow_stop_i,
  output logic fast_clk_o,
  output logic slow_clk_o,
  output logic fast_good_o,
  output logic slow_good_o,
  output logic slow_good_fast_o,
  output logic fast_good_slow_o,
  output logic sys_rst_n_o
);

  logic                  fast_rst_n;
  logic                  slow_rst_n;
  logic [FAST_CNT_W-1:0] fast_cnt;
  logic [SLOW_CNT_W-1:0] slow_cnt;
  tmr_stat_t             fast_stat;
  tmr_stat_t             slow_stat;
  logic                  fast_gate;
  logic                  slow_gate;
  logic                  req_n;
  logic                  req_sync;
  logic                  sys_q;
  logic                  sys_d;

  // Per-domain reset: asserted by power-on, released on the domain's clock.
  sup_sync #(.STAGES(SYNC_N)) u_fast_por (
    .clk_i    (fast_osc_i),
    .arst_n_i (por_n_i),
    .d_i      (1'b1),
    .q_o      (fast_rst_n)
  );

  sup_sync #(.STAGES(SYNC_N)) u_slow_por (
    .clk_i    (slow_osc_i),
    .arst_n_i (por_n_i),
    .d_i      (1'b1),
    .q_o      (slow_rst_n)
  );

  sup_settle_timer #(.CNT_W(FAST_CNT_W)) u_fast_tmr (
    .clk_i   (fast_osc_i),
    .rst_n_i (fast_rst_n),
    .stop_i  (fast_stop_i),
    .cnt_o   (fast_cnt),
    .stat_o  (fast_stat),
    .good_o  (fast_good_o),
    .clk_o   (fast_clk_o)
  );

  sup_settle_timer #(.CNT_W(SLOW_CNT_W)) u_slow_tmr (
    .clk_i   (slow_osc_i),
    .rst_n_i (slow_rst_n),
    .stop_i  (slow_stop_i),
    .cnt_o   (slow_cnt),
    .stat_o  (slow_stat),
    .good_o  (slow_good_o),
    .clk_o   (slow_clk_o)
  );

  assign fast_gate = fast_stat.gate;
  assign slow_gate = slow_stat.gate;

  // Good flags crossing into the opposite domain.
  sup_sync #(.STAGES(SYNC_N)) u_s2f (
    .clk_i    (fast_osc_i),
    .arst_n_i (fast_rst_n),
    .d_i      (slow_stat.good),
    .q_o      (slow_good_fast_o)
  );

  sup_sync #(.STAGES(SYNC_N)) u_f2s (
    .clk_i    (slow_osc_i),
    .arst_n_i (slow_rst_n),
    .d_i      (fast_stat.good),
    .q_o      (fast_good_slow_o)
  );

  // System reset: either source asserts at once, release is synchronised.
  assign req_n = por_n_i & ext_rst_n_i;

  sup_sync #(.STAGES(SYNC_N)) u_req (
    .clk_i    (fast_osc_i),
    .arst_n_i (req_n),
    .d_i      (1'b1),
    .q_o      (req_sync)
  );

  always_comb sys_d = req_sync & fast_good_o;

  always_ff @(posedge fast_osc_i or negedge req_n) begin
    if (!req_n) begin
      sys_q <= 1'b0;
    end else begin
      sys_q <= sys_d;
    end
  end

  assign sys_rst_n_o = sys_q;

endmodule

// File: rtl/sup_chk.sv
// Property checker for osc_startup_sup, attached by bind below.
module sup_chk #(
  parameter int unsigned FW = 14,
  parameter int unsigned SW = 6
) (
  input logic          fast_clk_i,
  input logic          slow_clk_i,
  input logic          por_n_i,
  input logic          ext_rst_n_i,
  input logic          fast_stop_i,
  input logic          slow_stop_i,
  input logic          fast_good_i,
  input logic          slow_good_i,
  input logic          fast_gate_i,
  input logic          slow_gate_i,
  input logic          sys_rst_n_i,
  input logic [FW-1:0] fast_cnt_i,
  input logic [SW-1:0] slow_cnt_i
);

  // R2
  fast_done_chk: assert property (@(posedge fast_clk_i) disable iff (!por_n_i)
    fast_good_i |-> (fast_cnt_i == '0));

  // R3
  slow_done_chk: assert property (@(posedge slow_clk_i) disable iff (!por_n_i)
    slow_good_i |-> (slow_cnt_i == '0));

  // R4
  fast_preset_chk: assert property (@(posedge fast_clk_i) disable iff (!por_n_i)
    fast_stop_i |=> (fast_cnt_i == {FW{1'b1}}));

  // R4
  slow_preset_chk: assert property (@(posedge slow_clk_i) disable iff (!por_n_i)
    slow_stop_i |=> (slow_cnt_i == {SW{1'b1}}));

  // R6
  fast_gate_chk: assert property (@(posedge fast_clk_i) disable iff (!por_n_i)
    fast_gate_i |-> (fast_cnt_i == '0));

  // R6
  slow_gate_chk: assert property (@(posedge slow_clk_i) disable iff (!por_n_i)
    slow_gate_i |-> (slow_cnt_i == '0));

  // R7
  ext_hold_chk: assert property (@(posedge fast_clk_i) disable iff (!por_n_i)
    !ext_rst_n_i |-> !sys_rst_n_i);

  // R8
  sys_release_chk: assert property (@(posedge fast_clk_i) disable iff (!por_n_i)
    $rose(sys_rst_n_i) |-> $past(fast_good_i));

endmodule

bind osc_startup_sup sup_chk #(
  .FW (FAST_CNT_W),
  .SW (SLOW_CNT_W)
) u_chk (
  .fast_clk_i  (fast_osc_i),
  .slow_clk_i  (slow_osc_i),
  .por_n_i     (por_n_i),
  .ext_rst_n_i (ext_rst_n_i),
  .fast_stop_i (fast_stop_i),
  .slow_stop_i (slow_stop_i),
  .fast_good_i (fast_good_o),
  .slow_good_i (slow_good_o),
  .fast_gate_i (fast_gate),
  .slow_gate_i (slow_gate),
  .sys_rst_n_i (sys_rst_n_o),
  .fast_cnt_i  (fast_cnt),
  .slow_cnt_i  (slow_cnt)
);

// File: tb/sim_osc_startup_sup.sv
// One time tick stands for 250 ps: the fast clock period of 16 ticks is 4 ns (250 MHz).
module sim_osc_startup_sup;

  localparam int FW   = 14;
  localparam int SW   = 6;
  localparam int FMAX = (1 << FW) - 1;
  localparam int SMAX = (1 << SW) - 1;

  logic fclk, sclk, por_n, ext_n, fstop, sstop;
  logic fast_clk_o, slow_clk_o, fast_good_o, slow_good_o;
  logic slow_good_fast_o, fast_good_slow_o, sys_rst_n_o;
  logic req_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_on = 0;

  // Behavioural reference state
  int fe = 0, se = 0, frem = FMAX, srem = SMAX;
  bit fgood_m = 0, sgood_m = 0, fs1 = 0, fs2 = 0, ss1 = 0, ss2 = 0;
  bit r1 = 0, r2 = 0, sys_m = 0, fen_m = 0, sen_m = 0;

  assign req_n = por_n & ext_n;

  osc_startup_sup #(.FAST_CNT_W(FW), .SLOW_CNT_W(SW), .SYNC_N(2)) u0 (
    .fast_osc_i       (fclk),
    .slow_osc_i       (sclk),
    .por_n_i          (por_n),
    .ext_rst_n_i      (ext_n),
    .fast_stop_i      (fstop),
    .slow_stop_i      (sstop),
    .fast_clk_o       (fast_clk_o),
    .slow_clk_o       (slow_clk_o),
    .fast_good_o      (fast_good_o),
    .slow_good_o      (slow_good_o),
    .slow_good_fast_o (slow_good_fast_o),
    .fast_good_slow_o (fast_good_slow_o),
    .sys_rst_n_o      (sys_rst_n_o)
  );

  initial begin
    fclk = 0;
    forever #8 fclk = ~fclk;
  end

  initial begin
    sclk = 0;
    #13;
    sclk = 1;
    forever #80 sclk = ~sclk;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at time %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic fstep();
    @(posedge fclk);
    #2;
  endtask

  task automatic sstep();
    @(posedge sclk);
    #1;
  endtask

  // Reference model, fast domain
  always @(posedge fclk or negedge por_n) begin
    if (!por_n) begin
      fe <= 0; frem <= FMAX; fgood_m <= 0; fs1 <= 0; fs2 <= 0;
    end else begin
      fs1 <= (fe >= 2) ? (sgood_m & !sstop) : 1'b0;
      fs2 <= (fe >= 2) ? fs1 : 1'b0;
      if (fe < 2) fe <= fe + 1;
      else if (fstop) begin
        frem <= FMAX; fgood_m <= 0;
      end else if (frem > 0) begin
        frem <= frem - 1;
        if (frem == 1) fgood_m <= 1;
      end
    end
  end

  always @(posedge fclk or negedge req_n) begin
    if (!req_n) begin
      r1 <= 0; r2 <= 0; sys_m <= 0;
    end else begin
      r1 <= 1; r2 <= r1; sys_m <= r2 & fgood_m & !fstop;
    end
  end

  always @(negedge fclk or negedge por_n) begin
    if (!por_n) fen_m <= 0;
    else        fen_m <= fgood_m & !fstop;
  end

  // Reference model, slow domain
  always @(posedge sclk or negedge por_n) begin
    if (!por_n) begin
      se <= 0; srem <= SMAX; sgood_m <= 0; ss1 <= 0; ss2 <= 0;
    end else begin
      ss1 <= (se >= 2) ? (fgood_m & !fstop) : 1'b0;
      ss2 <= (se >= 2) ? ss1 : 1'b0;
      if (se < 2) se <= se + 1;
      else if (sstop) begin
        srem <= SMAX; sgood_m <= 0;
      end else if (srem > 0) begin
        srem <= srem - 1;
        if (srem == 1) sgood_m <= 1;
      end
    end
  end

  always @(negedge sclk or negedge por_n) begin
    if (!por_n) sen_m <= 0;
    else        sen_m <= sgood_m & !sstop;
  end

  // Per-clock comparison against the model
  always begin
    @(negedge fclk);
    #2;
    if (cmp_on) begin
      chk("R2 fast good", fast_good_o, fgood_m & !fstop);
      chk("R8 system reset", sys_rst_n_o, sys_m);
      chk("R9 slow good into fast", slow_good_fast_o, fs2);
    end
  end

  always begin
    @(posedge fclk);
    #1;
    if (cmp_on) chk("R6 fast gated clock", fast_clk_o, fen_m);
  end

  always begin
    @(negedge sclk);
    #2;
    if (cmp_on) begin
      chk("R3 slow good", slow_good_o, sgood_m & !sstop);
      chk("R9 fast good into slow", fast_good_slow_o, ss2);
    end
  end

  always begin
    @(posedge sclk);
    #1;
    if (cmp_on) chk("R6 slow gated clock", slow_clk_o, sen_m);
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge fclk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    por_n = 1; ext_n = 1; fstop = 0; sstop = 0;
    #1;
    por_n = 0; ext_n = 0;
    repeat (4) fstep();
    cmp_on = 1;
    #1;
    // R1: reset state
    chk("R1 fast good", fast_good_o, 1'b0);
    chk("R1 slow good", slow_good_o, 1'b0);
    chk("R1 sys reset", sys_rst_n_o, 1'b0);
    chk("R1 fast clk", fast_clk_o, 1'b0);
    chk("R1 sync flags", slow_good_fast_o | fast_good_slow_o, 1'b0);

    fstep();
    por_n = 1;
    fork
      begin
        repeat (SMAX + 1) sstep();
        chk("R3 slow good before timeout", slow_good_o, 1'b0);
        sstep();
        chk("R3 slow good at timeout", slow_good_o, 1'b1);
      end
      begin
        repeat (FMAX) fstep();
        ext_n = 1;  // sync completes on the same edge the fast good rises
        fstep();
        chk("R2 fast good before timeout", fast_good_o, 1'b0);
        fstep();
        chk("R2 fast good at timeout", fast_good_o, 1'b1);
        chk("R8 sys reset same edge", sys_rst_n_o, 1'b0);
        fstep();
        chk("R8 sys reset released", sys_rst_n_o, 1'b1);
      end
    join

    repeat (3) sstep();
    chk("R9 fast good seen in slow domain", fast_good_slow_o, 1'b1);
    fstep();
    chk("R9 slow good seen in fast domain", slow_good_fast_o, 1'b1);

    // External reset pulse
    fstep();
    ext_n = 0;
    #1;
    chk("R7 sys reset asserts at once", sys_rst_n_o, 1'b0);
    chk("R10 fast good kept", fast_good_o, 1'b1);
    repeat (5) fstep();
    chk("R10 fast good after ext reset", fast_good_o, 1'b1);
    chk("R10 slow good after ext reset", slow_good_o, 1'b1);
    ext_n = 1;
    repeat (2) fstep();
    chk("R8 sys reset held during sync", sys_rst_n_o, 1'b0);
    fstep();
    chk("R8 sys reset after sync", sys_rst_n_o, 1'b1);

    // Main oscillator stop and restart
    fstep();
    fstop = 1;
    #1;
    chk("R4 fast good drops at once", fast_good_o, 1'b0);
    chk("R8 sys reset still registered", sys_rst_n_o, 1'b1);
    fstep();
    chk("R8 sys reset follows good", sys_rst_n_o, 1'b0);
    repeat (2) fstep();
    fstop = 0;
    repeat (FMAX - 1) fstep();
    chk("R4 fast good one before timeout", fast_good_o, 1'b0);
    fstep();
    chk("R4 fast good after restart", fast_good_o, 1'b1);
    chk("R8 sys reset lags good", sys_rst_n_o, 1'b0);
    fstep();
    chk("R8 sys reset after restart", sys_rst_n_o, 1'b1);

    // Slow stop landing on the terminal-count edge
    sstep();
    sstop = 1;
    #1;
    chk("R4 slow good drops at once", slow_good_o, 1'b0);
    repeat (2) sstep();
    sstop = 0;
    repeat (SMAX - 1) sstep();
    sstop = 1;
    sstep();
    sstop = 0;
    #1;
    chk("R5 stop wins over terminal count", slow_good_o, 1'b0);
    repeat (SMAX - 1) sstep();
    chk("R5 full delay restarted", slow_good_o, 1'b0);
    sstep();
    chk("R5 good after restarted delay", slow_good_o, 1'b1);

    // Power-on reset in mid-run
    fstep();
    por_n = 0;
    #1;
    chk("R1 fast good cleared", fast_good_o, 1'b0);
    chk("R1 slow good cleared", slow_good_o, 1'b0);
    chk("R1 sys reset asserted", sys_rst_n_o, 1'b0);
    fstep();
    chk("R1 sync flags cleared", slow_good_fast_o | fast_good_slow_o, 1'b0);
    fstep();
    por_n = 1;
    repeat (10) fstep();
    chk("R1 fast good restarts from preset", fast_good_o, 1'b0);
    repeat (5) fstep();

    done = 1;
    summary();
    $finish;
  end

endmodule